// File: doc/BRIEF.md
# Backlight PWM Dimming Controller

This block produces the dimming waveform and the power-on signal for an LED backlight. Software supplies an 8-bit brightness level and a period setting in prescaler ticks. The block forces the period into the band the backlight accepts, which is 100 Hz to 1 kHz. It maps brightness onto a duty band whose lower end is just above 5% and whose upper end is 100%. The waveform starts each period with its high phase. A full-brightness request gives a line that stays high.

A four-state machine controls the outputs. `ST_OFF` holds every backlight output low. The transition *power-up* (on request high) moves to `ST_ARM` for one cycle. `ST_ARM` raises the enable pin and latches the working settings. The transition *start* moves to `ST_HIGH`. The transition *fall* (high time used up) goes from `ST_HIGH` to `ST_LOW`. The transition *restart* (period used up) goes from either `ST_HIGH` or `ST_LOW` back to `ST_HIGH`, and it latches fresh settings. The transition *power-down* (on request low) leaves any state for `ST_OFF`. A dynamic-contrast flag is registered and passed straight through. It does not depend on the machine.

Top module: `bl_dim_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with the on request low, `pwm_o`, `bl_en_o` and `contrast_o` are all low.
- R2: One tick lasts CLK_HZ/TICK_HZ clock cycles. The period is P = `period_i` clamped to [TICK_HZ/1000, TICK_HZ/100] ticks, so a setting below the band gives the 1 kHz period and a setting above it gives the 100 Hz period.
- R3: The high time is H = M + (((P − M) · (L + L[7])) >> 8) ticks, where L is `level_i` and M = (13·P + 255) >> 8. A level of 0 therefore gives the minimum high time M, which is just above 5% of the period.
- R4: A level of 255 gives H = P, so `pwm_o` stays high through every period and has no low phase.
- R5: A change of `level_i` or `period_i` in the middle of a period leaves that period's high and low times unchanged. The new values apply from the next period start.
- R6: One clock edge after `on_req_i` is sampled low, `bl_en_o` and `pwm_o` are both low. `pwm_o` is never high while `bl_en_o` is low.
- R7: One edge after `on_req_i` is sampled high, `bl_en_o` is high and `pwm_o` is still low. On the following edge `pwm_o` goes high and the first period begins.
- R8: `contrast_o` equals `contrast_req_i` as sampled at the previous clock edge, whatever the on request is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | LVL_W | Brightness code |
| period_i | input | DIV_W | Requested period in ticks |
| on_req_i | input | 1 | Backlight-on request |
| contrast_req_i | input | 1 | Dynamic-contrast request |
| pwm_o | output | 1 | Dimming waveform |
| bl_en_o | output | 1 | Backlight enable |
| contrast_o | output | 1 | Dynamic-contrast enable |

## Verification
Each result arrives after a fixed number of edges:
- the enable and contrast pins respond one edge after their request;
- the dimming pin follows the enable pin by one more edge;
- high and low phases last whole multiples of the tick length.

The bench drives inputs and samples outputs on falling edges. It checks each pin at the exact falling edge where it is due. It measures phase widths by counting falling edges between two transitions of the dimming pin. Mid-period updates are checked by counting the rest of the period that was already running and then the period after it.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } bl_state_t;

    // Constant applied to the period to form the minimum high time (13/256).
    localparam int unsigned MIN_NUM = 13;

endpackage

// File: rtl/bl_dim_tick.sv
module bl_dim_tick #(
    parameter int unsigned TICK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = run_i && (pre_q == LAST);

endmodule

// File: rtl/bl_dim_duty.sv
module bl_dim_duty #(
    parameter int unsigned LVL_W   = 8,
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned PER_W   = 14,
    parameter int unsigned PER_MIN = 1000,
    parameter int unsigned PER_MAX = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [DIV_W-1:0] period_i,
    output logic [PER_W-1:0] eff_per_o,
    output logic [PER_W-1:0] eff_hi_o
);
    import bl_dim_pkg::*;

    localparam int unsigned MW = PER_W + 5;
    localparam int unsigned SW = PER_W + LVL_W + 1;

    logic [PER_W-1:0] per_c;
    logic [MW-1:0]    m13;
    logic [PER_W-1:0] min_hi;
    logic [PER_W-1:0] span;
    logic [LVL_W:0]   scale;
    logic [SW-1:0]    prod;
    logic [PER_W-1:0] hi_c;

    always_comb begin
        if (period_i < DIV_W'(PER_MIN)) begin
            per_c = PER_W'(PER_MIN);
        end else if (period_i > DIV_W'(PER_MAX)) begin
            per_c = PER_W'(PER_MAX);
        end else begin
            per_c = PER_W'(period_i);
        end
        m13    = MW'(per_c) * MW'(MIN_NUM) + MW'(255);
        min_hi = PER_W'(m13 >> 8);
        span   = per_c - min_hi;
        scale  = {1'b0, level_i} + {{LVL_W{1'b0}}, level_i[LVL_W-1]};
        prod   = SW'(span) * SW'(scale);
        hi_c   = min_hi + PER_W'(prod >> LVL_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_per_o <= PER_W'(PER_MIN);
            eff_hi_o  <= PER_W'(PER_MIN);
        end else begin
            eff_per_o <= per_c;
            eff_hi_o  <= hi_c;
        end
    end

endmodule

// File: rtl/bl_dim_fsm.sv
module bl_dim_fsm #(
    parameter int unsigned PER_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] eff_per_i,
    input  logic [PER_W-1:0] eff_hi_i,
    output logic             run_o,
    output logic             pwm_o,
    output logic             en_o
);
    import bl_dim_pkg::*;

    bl_state_t        state_q, state_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic [PER_W-1:0] per_q, per_d;
    logic [PER_W-1:0] hi_q, hi_d;
    logic [PER_W-1:0] cnt_inc;
    logic             per_end;

    assign cnt_inc = cnt_q + 1'b1;
    assign per_end = (cnt_inc == per_q);

    // Next-state and working-register logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        per_d   = per_q;
        hi_d    = hi_q;
        if (!on_i) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_ARM;
                end
                ST_ARM: begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    per_d   = eff_per_i;
                    hi_d    = eff_hi_i;
                end
                ST_HIGH: begin
                    if (tick_i) begin
                        if (per_end) begin
                            state_d = ST_HIGH;
                            cnt_d   = '0;
                            per_d   = eff_per_i;
                            hi_d    = eff_hi_i;
                        end else begin
                            cnt_d = cnt_inc;
                            if (cnt_inc == hi_q) begin
                                state_d = ST_LOW;
                            end
                        end
                    end
                end
                ST_LOW: begin
                    if (tick_i) begin
                        if (per_end) begin
                            state_d = ST_HIGH;
                            cnt_d   = '0;
                            per_d   = eff_per_i;
                            hi_d    = eff_hi_i;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            per_q   <= '1;
            hi_q    <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            per_q   <= per_d;
            hi_q    <= hi_d;
        end
    end

    // Moore outputs
    always_comb begin
        run_o = 1'b0;
        pwm_o = 1'b0;
        en_o  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_ARM: begin
                en_o = 1'b1;
            end
            ST_HIGH: begin
                en_o  = 1'b1;
                run_o = 1'b1;
                pwm_o = 1'b1;
            end
            ST_LOW: begin
                en_o  = 1'b1;
                run_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bl_dim_ctrl.sv
module bl_dim_ctrl #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_HZ = 1_000_000,
    parameter int unsigned LVL_W   = 8,
    parameter int unsigned DIV_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [DIV_W-1:0] period_i,
    input  logic             on_req_i,
    input  logic             contrast_req_i,
    output logic             pwm_o,
    output logic             bl_en_o,
    output logic             contrast_o
);
    localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;
    localparam int unsigned PER_MIN  = TICK_HZ / 1000;
    localparam int unsigned PER_MAX  = TICK_HZ / 100;
    localparam int unsigned PER_W    = $clog2(PER_MAX + 1);

    logic             run;
    logic             tick;
    logic [PER_W-1:0] eff_per;
    logic [PER_W-1:0] eff_hi;
    logic             contrast_q;

    bl_dim_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    bl_dim_duty #(
        .LVL_W   (LVL_W),
        .DIV_W   (DIV_W),
        .PER_W   (PER_W),
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX)
    ) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (level_i),
        .period_i  (period_i),
        .eff_per_o (eff_per),
        .eff_hi_o  (eff_hi)
    );

    bl_dim_fsm #(.PER_W(PER_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_i      (on_req_i),
        .tick_i    (tick),
        .eff_per_i (eff_per),
        .eff_hi_i  (eff_hi),
        .run_o     (run),
        .pwm_o     (pwm_o),
        .en_o      (bl_en_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            contrast_q <= 1'b0;
        end else begin
            contrast_q <= contrast_req_i;
        end
    end

    assign contrast_o = contrast_q;

endmodule

// File: rtl/bl_dim_chk.sv
module bl_dim_chk #(
    parameter int unsigned PER_W = 14,
    parameter int unsigned PMIN  = 1000,
    parameter int unsigned PMAX  = 10000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             on_req_i,
    input logic             contrast_req_i,
    input logic             pwm_o,
    input logic             bl_en_o,
    input logic             contrast_o,
    input logic [PER_W-1:0] eff_per,
    input logic [PER_W-1:0] eff_hi
);

    // R6
    off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_req_i |=> !bl_en_o);

    // R6
    pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bl_en_o |-> !pwm_o);

    // R7
    arm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en_o) |-> !pwm_o);

    // R7
    arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en_o) |=> (pwm_o || !bl_en_o));

    // R2
    per_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_per >= PER_W'(PMIN)) && (eff_per <= PER_W'(PMAX)));

    // R3
    hi_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_hi != '0) && (eff_hi <= eff_per));

    // R8
    contrast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        contrast_req_i |=> contrast_o);

    // R8
    contrast_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !contrast_req_i |=> !contrast_o);

endmodule

bind bl_dim_ctrl bl_dim_chk #(
    .PER_W (PER_W),
    .PMIN  (PER_MIN),
    .PMAX  (PER_MAX)
) u_chk (.*);

// File: tb/test_bl_dim_ctrl.sv
`timescale 1ns/1ps
module test_bl_dim_ctrl;

    localparam int unsigned CLK_HZ  = 400_000;
    localparam int unsigned TICK_HZ = 40_000;
    localparam int unsigned TD      = CLK_HZ / TICK_HZ;
    localparam int unsigned PMIN    = TICK_HZ / 1000;
    localparam int unsigned PMAX    = TICK_HZ / 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  level = 8'd0;
    logic [15:0] period = 16'd100;
    logic        on_req = 1'b0;
    logic        creq = 1'b0;
    logic        pwm, en, cout;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bl_dim_ctrl #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .LVL_W(8), .DIV_W(16)) i_bl_dim_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .level_i        (level),
        .period_i       (period),
        .on_req_i       (on_req),
        .contrast_req_i (creq),
        .pwm_o          (pwm),
        .bl_en_o        (en),
        .contrast_o     (cout)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_per(input int d);
        if (d < PMIN) return PMIN;
        if (d > PMAX) return PMAX;
        return d;
    endfunction

    function automatic int exp_hi(input int d, input int l);
        int p, m;
        p = exp_per(d);
        m = (13 * p + 255) / 256;
        return m + ((p - m) * (l + l / 128)) / 256;
    endfunction

    task automatic start(input int d, input int l);
        @(negedge clk);
        on_req = 1'b0;
        period = 16'(d);
        level  = 8'(l);
        repeat (3) @(negedge clk);
        on_req = 1'b1;
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (pwm) @(negedge clk);
        while (!pwm) @(negedge clk);
        while (pwm && hi < 5000) begin hi++; @(negedge clk); end
        while (!pwm && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 pwm in reset", pwm, 0);
        check("R1 en in reset", en, 0);
        check("R1 contrast in reset", cout, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 pwm after reset", pwm, 0);
        check("R1 en after reset", en, 0);
    endtask

    task automatic t_arm();
        start(100, 0);
        @(negedge clk);
        check("R7 en after one edge", en, 1);
        check("R7 pwm gap", pwm, 0);
        @(negedge clk);
        check("R7 pwm starts", pwm, 1);
    endtask

    task automatic t_shape(input string req, input int d, input int l);
        int hi, lo, eh;
        start(d, l);
        measure(hi, lo);
        eh = exp_hi(d, l) * TD;
        check({req, " high cycles"}, hi, eh);
        check({req, " low cycles"}, lo, exp_per(d) * TD - eh);
    endtask

    task automatic t_full();
        int lows = 0;
        start(100, 255);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2500; i++) begin
            if (!pwm) lows++;
            @(negedge clk);
        end
        check("R4 low samples at level 255", lows, 0);
    endtask

    task automatic t_update();
        int hi = 0, lo = 0, lows = 0;
        start(100, 0);
        @(negedge clk);
        while (!pwm) @(negedge clk);
        repeat (10) begin hi++; @(negedge clk); end
        level = 8'd255;
        while (pwm && hi < 5000) begin hi++; @(negedge clk); end
        while (!pwm && lo < 5000) begin lo++; @(negedge clk); end
        check("R5 running period high kept", hi, exp_hi(100, 0) * TD);
        check("R5 running period low kept", lo, 100 * TD - exp_hi(100, 0) * TD);
        for (int i = 0; i < 1000; i++) begin
            if (!pwm) lows++;
            @(negedge clk);
        end
        check("R5 next period uses new level", lows, 0);
    endtask

    task automatic t_off();
        start(100, 255);
        repeat (20) @(negedge clk);
        on_req = 1'b0;
        @(negedge clk);
        check("R6 en low after request drop", en, 0);
        check("R6 pwm low after request drop", pwm, 0);
        repeat (50) @(negedge clk);
        check("R6 pwm stays low", pwm, 0);
    endtask

    task automatic t_contrast();
        on_req = 1'b0;
        @(negedge clk);
        creq = 1'b1;
        @(negedge clk);
        check("R8 contrast high while off", cout, 1);
        check("R8 enable unaffected", en, 0);
        creq = 1'b0;
        @(negedge clk);
        check("R8 contrast cleared", cout, 0);
        on_req = 1'b1;
        creq = 1'b1;
        @(negedge clk);
        check("R8 contrast high while on", cout, 1);
        creq = 1'b0;
    endtask

    initial begin
        t_reset();
        t_arm();
        t_shape("R3 mid level", 100, 128);
        t_shape("R3 level zero minimum", 100, 0);
        t_shape("R2 short period clamp", 5, 0);
        t_shape("R2 long period clamp", 1000, 0);
        t_shape("R2 in-band period", 250, 64);
        t_full();
        t_update();
        t_off();
        t_contrast();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule